// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Interface with Store Buffer

This block sits between a processor core and an external 32-bit bus on which address and data share the same wires. Stores from the core enter a four-entry first-in, first-out buffer in a single core cycle, so the core keeps running while the slower bus retires them one after another. Loads are issued as either a single-word read or a four-word block read. The returned words collect in a four-word read buffer, and the core is told with a one-cycle completion pulse when the buffer is complete.

Every bus transaction starts with one address phase, marked by the address-latch-enable output, while the block drives the address onto the shared wires. One or more data phases follow. Each data phase completes on an acknowledge from the memory side, which may be held off for any number of wait states. A configuration input slows the bus to every other core cycle, and a `bus_tick` output tells the memory side which cycles count. A second input adds an idle bus cycle after read data, so the memory can release the wires before the next address is driven. Pending stores always go out before a read is started. Because of this, a read never returns data older than a store that the core issued earlier.

Top module: `mux_bus_unit`

## Requirements
- R1: After reset, `ale`, `ad_oe`, `bus_rd`, `bus_wr`, `rd_busy` and `rd_done` are low and `st_ready` is high.
- R2: A store offered with `st_valid` while `st_ready` is high is taken in that cycle. `st_ready` is low exactly while four stores are held.
- R3: Each transaction begins with an address phase in which `ale` is high, `ad_oe` is high and `ad_out` carries the address. In full-rate mode this phase lasts one core cycle, and no data strobe is active during it.
- R4: A data phase ends only at a bus tick on which `bus_ack` is high. With N wait states before the acknowledge, a write data phase lasts N+1 bus ticks.
- R5: Buffered stores reach the bus in the order they were accepted. In each write data phase, `bus_wr` and `ad_oe` are high and `ad_out` carries the store data.
- R6: A read's address phase starts only when the store buffer was empty on the preceding bus tick. Pending stores win over a pending read.
- R7: A read with `rd_burst`=0 has one data beat. The word lands in `rd_data[31:0]`, `rd_count` is 1, and `rd_done` is high for exactly one cycle.
- R8: A read with `rd_burst`=1 has one address phase followed by four data beats. Beat k lands in `rd_data[32k+31:32k]`, and `rd_count` is 4.
- R9: `rd_req` is ignored while `rd_busy` is high. No second read appears on the bus.
- R10: With `cfg_half_rate`=1, `bus_tick` is high on alternate core cycles and the bus outputs change only after a tick. An address phase then lasts two core cycles.
- R11: In full-rate mode, the next address phase starts 2 core cycles after the cycle of a read's final acknowledge. With `cfg_slow_turn`=1 it starts 3 core cycles after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half_rate | input | 1 | Bus advances on alternate core cycles |
| cfg_slow_turn | input | 1 | Extra idle bus tick after read data |
| st_valid | input | 1 | Core offers a store |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store buffer has room |
| rd_req | input | 1 | Core requests a read |
| rd_addr | input | 32 | Read address |
| rd_burst | input | 1 | 1 = four-word block read, 0 = single word |
| rd_busy | output | 1 | A read is pending or in progress |
| rd_done | output | 1 | One-cycle pulse: read buffer complete |
| rd_count | output | 3 | Number of words delivered by the last read |
| rd_data | output | 128 | Read buffer, word k at bits 32k+31:32k |
| bus_tick | output | 1 | Current core cycle is a bus cycle |
| ale | output | 1 | Address phase marker |
| ad_oe | output | 1 | Block drives the shared wires |
| ad_out | output | 32 | Address or write data driven |
| ad_in | input | 32 | Read data from the shared wires |
| bus_rd | output | 1 | Read data phase |
| bus_wr | output | 1 | Write data phase |
| bus_ack | input | 1 | Data phase acknowledge |

## Verification
The collision that matters is a core store arriving while the bus is busy with a read, or just before a read is dispatched. The read has to go first only when it was already on the bus, and otherwise the pending stores must drain ahead of it. The bench queues three stores and then a read in consecutive cycles. It checks that the read's address phase comes after exactly three write acknowledges. It also pushes a store during a block read and measures the cycle gap between the final read acknowledge and the store's address phase, with and without slow turnaround.

// File: rtl/mux_bus_unit.sv
module mux_bus_unit #(
  parameter int BUS_W     = 32,
  parameter int WB_DEPTH  = 4,
  parameter int BURST_LEN = 4
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_half_rate,
  input  logic                       cfg_slow_turn,
  input  logic                       st_valid,
  input  logic [BUS_W-1:0]           st_addr,
  input  logic [BUS_W-1:0]           st_data,
  output logic                       st_ready,
  input  logic                       rd_req,
  input  logic [BUS_W-1:0]           rd_addr,
  input  logic                       rd_burst,
  output logic                       rd_busy,
  output logic                       rd_done,
  output logic [$clog2(BURST_LEN+1)-1:0] rd_count,
  output logic [BURST_LEN*BUS_W-1:0] rd_data,
  output logic                       bus_tick,
  output logic                       ale,
  output logic                       ad_oe,
  output logic [BUS_W-1:0]           ad_out,
  input  logic [BUS_W-1:0]           ad_in,
  output logic                       bus_rd,
  output logic                       bus_wr,
  input  logic                       bus_ack
);
  localparam int PTR_W  = $clog2(WB_DEPTH);
  localparam int CNT_W  = $clog2(WB_DEPTH + 1);
  localparam int BEAT_W = $clog2(BURST_LEN);
  localparam int RCNT_W = $clog2(BURST_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_TURN} bus_state_t;

  bus_state_t        state;
  logic              phase;
  logic              is_read;
  logic              rd_pend;
  logic [BUS_W-1:0]  rd_a;
  logic              rd_b;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] last_beat;
  logic              done_q;
  logic [RCNT_W-1:0] count_q;

  logic [BUS_W-1:0]  wb_addr [WB_DEPTH];
  logic [BUS_W-1:0]  wb_data [WB_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  wb_count;
  logic [BUS_W-1:0]  rbuf [BURST_LEN];

  logic push, pop, beat_end;

  assign bus_tick  = !cfg_half_rate || phase;
  assign st_ready  = wb_count != CNT_W'(WB_DEPTH);
  assign push      = st_valid && st_ready;
  assign beat_end  = (state == S_DATA) && bus_tick && bus_ack;
  assign pop       = beat_end && !is_read;
  assign last_beat = rd_b ? BEAT_W'(BURST_LEN - 1) : '0;

  assign ale      = state == S_ADDR;
  assign bus_wr   = (state == S_DATA) && !is_read;
  assign bus_rd   = (state == S_DATA) && is_read;
  assign ad_oe    = ale || bus_wr;
  assign rd_busy  = rd_pend;
  assign rd_done  = done_q;
  assign rd_count = count_q;

  always_comb begin
    ad_out = '0;
    if (ale)         ad_out = is_read ? rd_a : wb_addr[rd_ptr];
    else if (bus_wr) ad_out = wb_data[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push) begin
      wb_addr[wr_ptr] <= st_addr;
      wb_data[wr_ptr] <= st_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      wb_count <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   wb_count <= wb_count + CNT_W'(1);
        2'b01:   wb_count <= wb_count - CNT_W'(1);
        default: wb_count <= wb_count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= 1'b1;
    else        phase <= !phase;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_a    <= '0;
      rd_b    <= 1'b0;
    end else if (rd_req && !rd_pend) begin
      rd_pend <= 1'b1;
      rd_a    <= rd_addr;
      rd_b    <= rd_burst;
    end else if (beat_end && is_read && beat == last_beat) begin
      rd_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      is_read <= 1'b0;
      beat    <= '0;
      done_q  <= 1'b0;
      count_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (bus_tick) begin
        case (state)
          S_IDLE: begin
            if (wb_count != '0) begin
              state   <= S_ADDR;
              is_read <= 1'b0;
            end else if (rd_pend) begin
              state   <= S_ADDR;
              is_read <= 1'b1;
              beat    <= '0;
            end
          end
          S_ADDR: state <= S_DATA;
          S_DATA: begin
            if (bus_ack) begin
              if (!is_read) begin
                state <= S_IDLE;
              end else if (beat == last_beat) begin
                done_q  <= 1'b1;
                count_q <= RCNT_W'(beat) + RCNT_W'(1);
                state   <= cfg_slow_turn ? S_TURN : S_IDLE;
              end else begin
                beat <= beat + BEAT_W'(1);
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BURST_LEN; i++) rbuf[i] <= '0;
    end else if (beat_end && is_read) begin
      rbuf[beat] <= ad_in;
    end
  end

  for (genvar g = 0; g < BURST_LEN; g++) begin : g_rflat
    assign rd_data[g*BUS_W +: BUS_W] = rbuf[g];
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !ale && !ad_oe && !rd_done); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) wb_count <= CNT_W'(WB_DEPTH)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (wb_count == CNT_W'(WB_DEPTH) && !pop) |=> !st_ready); // R2
  AST_ALE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) ale |-> ad_oe && !bus_rd && !bus_wr); // R3
  AST_ALE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_half_rate && ale) |=> !ale); // R3
  AST_ACK_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && !(bus_tick && bus_ack)) |=> bus_wr); // R4
  AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) ($rose(ale) && is_read) |-> $past(wb_count) == '0); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_done |=> !rd_done); // R7
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cfg_half_rate && !bus_tick) |=> $stable(ale) && $stable(bus_rd) && $stable(bus_wr)); // R10
endmodule

// File: tb/tb_mux_bus_unit.sv
`timescale 1ns/1ps
module tb_mux_bus_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_half_rate = 1'b0, cfg_slow_turn = 1'b0;
  logic st_valid = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic st_ready;
  logic rd_req = 1'b0;
  logic [31:0] rd_addr = '0;
  logic rd_burst = 1'b0;
  logic rd_busy, rd_done;
  logic [2:0] rd_count;
  logic [127:0] rd_data;
  logic bus_tick, ale, ad_oe, bus_rd, bus_wr;
  logic [31:0] ad_out;
  logic [31:0] ad_in = '0;
  logic bus_ack = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_half_rate(cfg_half_rate), .cfg_slow_turn(cfg_slow_turn),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_burst(rd_burst), .rd_busy(rd_busy),
    .rd_done(rd_done), .rd_count(rd_count), .rd_data(rd_data), .bus_tick(bus_tick),
    .ale(ale), .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_ack(bus_ack));

  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0100, 32'hDEAD_0001}, {32'h0000_0204, 32'h1234_5678},
    {32'hFFFF_FFFC, 32'h0000_0000}, {32'h8000_0000, 32'hFFFF_FFFF},
    {32'h0000_0100, 32'hA5A5_A5A5}, {32'h1357_9BD0, 32'h0F0F_F0F0}};

  int checks = 0, fails = 0;
  int cyc = 0;
  int wait_cfg = 0, wcnt = 0, beat = 0;
  int wn = 0, an = 0, ale_run = 0, last_ale_len = 0, wr_cycles = 0;
  int last_ale_cyc = 0, last_rack_cyc = 0;
  logic [31:0] cur_a = '0;
  logic [31:0] wlog_a [64], wlog_d [64], alog [64];
  int alog_wn [64];

  function automatic logic [31:0] rword(input logic [31:0] a, input int k);
    return (a + 32'(k * 4)) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (ale) begin
      if (ale_run == 0 && an < 64) begin
        alog[an] = ad_out; alog_wn[an] = wn; an++;
        cur_a = ad_out; beat = 0; last_ale_cyc = cyc;
      end
      ale_run++;
    end else begin
      if (ale_run != 0) last_ale_len = ale_run;
      ale_run = 0;
    end
    if (bus_wr) wr_cycles++;
    if (bus_tick && (bus_rd || bus_wr)) begin
      if (wcnt >= wait_cfg) begin
        bus_ack = 1'b1; wcnt = 0;
        if (bus_wr) begin
          if (wn < 64) begin wlog_a[wn] = cur_a; wlog_d[wn] = ad_out; end
          wn++;
        end else begin
          ad_in = rword(cur_a, beat); beat++; last_rack_cyc = cyc;
        end
      end else begin
        bus_ack = 1'b0; wcnt++;
      end
    end else if (bus_tick || !(bus_rd || bus_wr)) begin
      bus_ack = 1'b0;
    end else begin
      bus_ack = 1'b0;
    end
  end

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!st_ready) @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    @(posedge clk); #1 st_valid = 1'b0;
  endtask

  task automatic read(input logic [31:0] a, input logic b);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; rd_burst = b;
    @(posedge clk); #1 rd_req = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    while (wn < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!rd_done);
  endtask

  initial begin
    int base, a0;
    logic t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ale && !ad_oe && !bus_rd && !bus_wr && !rd_busy && !rd_done && st_ready, "R1 reset",
        {26'b0, ale, ad_oe, bus_rd, bus_wr, rd_busy, rd_done}, 32'h0);

    // R5 / R3: table of stores, drained in order
    for (int i = 0; i < 6; i++) store(VEC[i][63:32], VEC[i][31:0]);
    wait_writes(6);
    for (int i = 0; i < 6; i++) begin
      chk(alog[i] == VEC[i][63:32], "R3 address phase", alog[i], VEC[i][63:32]);
      chk(wlog_d[i] == VEC[i][31:0], "R5 fifo order data", wlog_d[i], VEC[i][31:0]);
    end
    chk(last_ale_len == 1, "R3 ale width full rate", 32'(last_ale_len), 32'd1);

    // R4: wait states stretch the data phase
    wait_cfg = 3; wr_cycles = 0;
    store(32'h0000_4440, 32'hCAFE_0004);
    wait_writes(7);
    chk(wr_cycles == 4, "R4 wait states", 32'(wr_cycles), 32'd4);
    chk(wlog_d[6] == 32'hCAFE_0004, "R4 data", wlog_d[6], 32'hCAFE_0004);

    // R2: stall when four held
    wait_cfg = 6;
    for (int i = 0; i < 3; i++) store(32'h100 + 32'(i * 4), 32'hB000_0000 + 32'(i));
    @(negedge clk);
    chk(st_ready == 1'b1, "R2 room at three", {31'b0, st_ready}, 32'd1);
    store(32'h10C, 32'hB000_0003);
    @(negedge clk);
    chk(st_ready == 1'b0, "R2 full at four", {31'b0, st_ready}, 32'd0);
    store(32'h110, 32'hB000_0004);
    wait_writes(12);
    for (int i = 0; i < 5; i++)
      chk(wlog_d[7 + i] == 32'hB000_0000 + 32'(i), "R5 order after stall", wlog_d[7 + i], 32'hB000_0000 + 32'(i));

    // R7: single read
    wait_cfg = 0;
    read(32'h0000_1000, 1'b0);
    wait_done();
    chk(rd_count == 3'd1, "R7 count", {29'b0, rd_count}, 32'd1);
    chk(rd_data[31:0] == rword(32'h1000, 0), "R7 data", rd_data[31:0], rword(32'h1000, 0));
    @(negedge clk);
    chk(!rd_done && !rd_busy, "R7 done pulse", {30'b0, rd_done, rd_busy}, 32'd0);

    // R8: burst read
    wait_cfg = 1; a0 = an;
    read(32'h0000_2000, 1'b1);
    wait_done();
    chk(rd_count == 3'd4, "R8 count", {29'b0, rd_count}, 32'd4);
    for (int k = 0; k < 4; k++)
      chk(rd_data[k*32 +: 32] == rword(32'h2000, k), "R8 burst word", rd_data[k*32 +: 32], rword(32'h2000, k));
    chk(an == a0 + 1, "R8 one address phase", 32'(an), 32'(a0 + 1));

    // R6: stores queued before a read drain first
    wait_cfg = 2; base = wn; a0 = an;
    for (int i = 0; i < 3; i++) store(32'h600 + 32'(i * 4), 32'hC000_0000 + 32'(i));
    read(32'h0000_6000, 1'b0);
    wait_done();
    chk(alog[a0 + 3] == 32'h6000, "R6 read after writes", alog[a0 + 3], 32'h6000);
    chk(alog_wn[a0 + 3] == base + 3, "R6 drained count", 32'(alog_wn[a0 + 3]), 32'(base + 3));
    chk(rd_data[31:0] == rword(32'h6000, 0), "R6 read data", rd_data[31:0], rword(32'h6000, 0));

    // R9: request while busy is ignored
    wait_cfg = 0; a0 = an;
    read(32'h0000_3000, 1'b1);
    read(32'h0000_4000, 1'b0);
    wait_done();
    repeat (10) @(negedge clk);
    chk(an == a0 + 1, "R9 ignored request", 32'(an), 32'(a0 + 1));
    chk(!rd_busy, "R9 not busy", {31'b0, rd_busy}, 32'd0);
    chk(rd_data[127:96] == rword(32'h3000, 3), "R9 first read intact", rd_data[127:96], rword(32'h3000, 3));

    // R11: turnaround gap, normal then slow
    for (int m = 0; m < 2; m++) begin
      cfg_slow_turn = m[0]; base = wn;
      read(32'h0000_5000, 1'b1);
      do @(negedge clk); while (!bus_rd);
      store(32'h0000_5500, 32'hD000_0000 + 32'(m));
      wait_writes(base + 1);
      chk(last_ale_cyc - last_rack_cyc == 2 + m, "R11 turnaround gap",
          32'(last_ale_cyc - last_rack_cyc), 32'(2 + m));
    end
    cfg_slow_turn = 1'b0;

    // R10: half-rate bus
    cfg_half_rate = 1'b1; base = wn;
    @(negedge clk); t0 = bus_tick;
    @(negedge clk);
    chk(bus_tick != t0, "R10 tick alternates", {31'b0, bus_tick}, {31'b0, !t0});
    store(32'h0000_7700, 32'hE000_0077);
    wait_writes(base + 1);
    chk(last_ale_len == 2, "R10 ale two cycles", 32'(last_ale_len), 32'd2);
    chk(wlog_d[base] == 32'hE000_0077, "R10 write data", wlog_d[base], 32'hE000_0077);
    wait_cfg = 1;
    read(32'h0000_8000, 1'b1);
    wait_done();
    for (int k = 0; k < 4; k++)
      chk(rd_data[k*32 +: 32] == rword(32'h8000, k), "R10 burst word", rd_data[k*32 +: 32], rword(32'h8000, k));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule